// File: doc/BRIEF.md
# SDRAM Command Front End with Data Mask Timing

This block is the device-side front end of a synchronous DRAM behavioural model. On each rising clock edge where the clock enable is high, it samples chip select and the three active-low strobe lines. It turns each legal combination into a one-cycle registered command pulse. It keeps an open or closed flag for each bank, enforces which commands are legal against those flags, and closes a bank on its own when a read or write carries the auto-precharge request.

A second path shapes the data mask. For reads, the mask works as an output enable and takes effect two enabled edges after it is sampled. For writes, it acts in the same cycle as a per-byte write strobe. The storage array and the burst address counter sit outside this block. Of the address bus, only the bank select and the precharge-control bit (address bit 10) enter it.

Top module: `sdram_cmd_front`

## Requirements
- R1: With cs_ni low and cke_i high, {ras_ni,cas_ni,we_ni} is decoded as follows: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set. Each decoded command sets its strobe for exactly the cycle after the sampling edge. The codes 111 (no operation) and 110 (burst stop) raise no strobe.
- R2: While cs_ni is high, no command is taken and no strobe rises. A pending auto-precharge keeps counting down.
- R3: On an edge where cke_i is low, the strobes, the bank flags, the auto-precharge countdown and the read-mask pipeline all hold their values. wr_byte_en_o is 0 while cke_i is low.
- R4: An activate to a closed bank sets its bit in bank_open_o. An activate to a bank that is already open raises cmd_err_o instead of act_o and changes no flag.
- R5: A read or write to a closed bank raises cmd_err_o instead of read_o or write_o and changes no state.
- R6: A precharge with a10_i low closes only the bank on ba_i. A precharge with a10_i high closes every bank, whatever ba_i holds.
- R7: A read or write with a10_i high closes its bank BURST_LEN enabled edges after the command edge (default 4), that is, on the edge after the last beat.
- R8: rd_byte_en_o equals the inverse of dqm_i as sampled two enabled edges earlier, bit 0 for the lower byte and bit 1 for the upper byte.
- R9: wr_byte_en_o equals the inverse of dqm_i in the same cycle while cke_i is high. A high mask bit blocks that byte.
- R10: During and right after reset, every strobe is low, every bank is closed and rd_byte_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable; low freezes internal state |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank select |
| a10_i | input | 1 | Auto-precharge / precharge-all control |
| dqm_i | input | 2 | Byte data mask, bit 0 lower, bit 1 upper |
| act_o | output | 1 | Activate accepted |
| read_o | output | 1 | Read accepted |
| write_o | output | 1 | Write accepted |
| pre_o | output | 1 | Precharge accepted |
| refresh_o | output | 1 | Refresh accepted |
| mode_o | output | 1 | Mode set accepted |
| cmd_err_o | output | 1 | Illegal command for the current bank state |
| bank_open_o | output | 4 | Open flag per bank |
| rd_byte_en_o | output | 2 | Read output enable per byte |
| wr_byte_en_o | output | 2 | Write strobe per byte |

## Verification
The command decoder is exercised with every opcode. Each one is sent to an open bank and to a closed bank, which separates correct decoding from legality checking. An activate pattern sent while deselected shows that chip select really gates the decoder. A frozen edge placed in the middle of an auto-precharge countdown shows whether the closing edge counts only enabled clocks. Mask values that change on every step, with a single byte masked at a time, show whether the read path has the right two-edge delay and the write path has none, and whether the two bytes are swapped.

// File: rtl/sdcf_pkg.sv
package sdcf_pkg;

   typedef enum logic [2:0] {
      OP_IDLE, OP_OPEN, OP_RD, OP_WR, OP_CLOSE, OP_REFR, OP_MODE, OP_HALT
   } sdcf_op_e;

   // Maps the active-low row/column/write strobe triple to an operation.
   function automatic sdcf_op_e op_of(input logic ras_n, input logic cas_n,
                                      input logic we_n);
      unique case ({ras_n, cas_n, we_n})
         3'b011:  return OP_OPEN;
         3'b101:  return OP_RD;
         3'b100:  return OP_WR;
         3'b010:  return OP_CLOSE;
         3'b001:  return OP_REFR;
         3'b000:  return OP_MODE;
         3'b110:  return OP_HALT;
         default: return OP_IDLE;
      endcase
   endfunction

endpackage

// File: rtl/sdcf_decode.sv
module sdcf_decode
   import sdcf_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BA_W      = 2
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 cke_i,
   input  logic                 cs_ni,
   input  logic                 ras_ni,
   input  logic                 cas_ni,
   input  logic                 we_ni,
   input  logic [BA_W-1:0]      ba_i,
   input  logic                 a10_i,
   input  logic [NUM_BANKS-1:0] bank_open_i,
   output logic                 open_ev_o,
   output logic                 close_ev_o,
   output logic                 close_all_o,
   output logic                 access_ev_o,
   output logic                 auto_close_o,
   output logic                 act_o,
   output logic                 read_o,
   output logic                 write_o,
   output logic                 pre_o,
   output logic                 refresh_o,
   output logic                 mode_o,
   output logic                 cmd_err_o
);

   if (NUM_BANKS != (1 << BA_W)) begin : g_bad_banks
      $error("NUM_BANKS must equal 2**BA_W");
   end

   sdcf_op_e op;
   logic     tgt_open;
   logic     is_access;
   logic     bad;

   always_comb begin
      op        = cs_ni ? OP_IDLE : op_of(ras_ni, cas_ni, we_ni);
      tgt_open  = bank_open_i[ba_i];
      is_access = (op == OP_RD) || (op == OP_WR);
      bad       = ((op == OP_OPEN) && tgt_open) || (is_access && !tgt_open);
   end

   assign open_ev_o    = cke_i && (op == OP_OPEN) && !tgt_open;
   assign close_ev_o   = cke_i && (op == OP_CLOSE);
   assign close_all_o  = a10_i;
   assign access_ev_o  = cke_i && is_access && tgt_open;
   assign auto_close_o = a10_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_o     <= 1'b0;
         read_o    <= 1'b0;
         write_o   <= 1'b0;
         pre_o     <= 1'b0;
         refresh_o <= 1'b0;
         mode_o    <= 1'b0;
         cmd_err_o <= 1'b0;
      end else if (cke_i) begin
         act_o     <= (op == OP_OPEN) && !bad;
         read_o    <= (op == OP_RD) && !bad;
         write_o   <= (op == OP_WR) && !bad;
         pre_o     <= (op == OP_CLOSE);
         refresh_o <= (op == OP_REFR);
         mode_o    <= (op == OP_MODE);
         cmd_err_o <= bad;
      end
   end

   // R1: at most one strobe or the error flag per cycle
   assert_single_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({act_o, read_o, write_o, pre_o, refresh_o, mode_o, cmd_err_o}));

   // R2: an enabled but deselected edge yields no strobe
   assert_deselect_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(cs_ni) && $past(cke_i)) |->
      !(act_o || read_o || write_o || pre_o || refresh_o || mode_o || cmd_err_o));

endmodule

// File: rtl/sdcf_bank_track.sv
module sdcf_bank_track #(
   parameter int NUM_BANKS = 4,
   parameter int BA_W      = 2,
   parameter int BURST_LEN = 4
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 cke_i,
   input  logic [BA_W-1:0]      ba_i,
   input  logic                 open_ev_i,
   input  logic                 close_ev_i,
   input  logic                 close_all_i,
   input  logic                 access_ev_i,
   input  logic                 auto_close_i,
   output logic [NUM_BANKS-1:0] bank_open_o
);

   localparam int CNT_W = $clog2(BURST_LEN + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(BURST_LEN);

   if (BURST_LEN < 1) begin : g_bad_len
      $error("BURST_LEN must be at least 1");
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic             open_q;
      logic [CNT_W-1:0] left_q;
      logic             hit;

      assign hit = (ba_i == BA_W'(b));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            open_q <= 1'b0;
            left_q <= '0;
         end else if (cke_i) begin
            if (open_ev_i && hit) begin
               open_q <= 1'b1;
               left_q <= '0;
            end else if (close_ev_i && (close_all_i || hit)) begin
               open_q <= 1'b0;
               left_q <= '0;
            end else if (access_ev_i && hit) begin
               left_q <= auto_close_i ? LOAD : '0;
            end else if (left_q != '0) begin
               left_q <= left_q - 1'b1;
               if (left_q == CNT_W'(1)) open_q <= 1'b0;
            end
         end
      end

      assign bank_open_o[b] = open_q;
   end

   // R6: a precharge with the all-banks bit closes every bank
   assert_close_all_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cke_i && close_ev_i && close_all_i) |=> (bank_open_o == '0));

   // R3: a disabled edge leaves the bank flags untouched
   assert_freeze_banks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cke_i |=> $stable(bank_open_o));

endmodule

// File: rtl/sdcf_mask_pipe.sv
module sdcf_mask_pipe #(
   parameter int MASK_W = 2,
   parameter int RD_LAT = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cke_i,
   input  logic [MASK_W-1:0] dqm_i,
   output logic [MASK_W-1:0] rd_byte_en_o,
   output logic [MASK_W-1:0] wr_byte_en_o
);

   if (RD_LAT < 1) begin : g_bad_lat
      $error("RD_LAT must be at least 1");
   end

   if (RD_LAT == 1) begin : g_one
      logic [MASK_W-1:0] en_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)    en_q <= '0;
         else if (cke_i) en_q <= ~dqm_i;
      end
      assign rd_byte_en_o = en_q;
   end else begin : g_chain
      logic [MASK_W-1:0] en_q [RD_LAT];
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            for (int i = 0; i < RD_LAT; i++) en_q[i] <= '0;
         end else if (cke_i) begin
            en_q[0] <= ~dqm_i;
            for (int i = 1; i < RD_LAT; i++) en_q[i] <= en_q[i-1];
         end
      end
      assign rd_byte_en_o = en_q[RD_LAT-1];
   end

   assign wr_byte_en_o = cke_i ? ~dqm_i : '0;

   // R3: the read enable holds across a disabled edge
   assert_freeze_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cke_i |=> $stable(rd_byte_en_o));

endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front #(
   parameter int NUM_BANKS = 4,
   parameter int BA_W      = 2,
   parameter int BURST_LEN = 4,
   parameter int MASK_W    = 2,
   parameter int RD_LAT    = 2
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 cke_i,
   input  logic                 cs_ni,
   input  logic                 ras_ni,
   input  logic                 cas_ni,
   input  logic                 we_ni,
   input  logic [BA_W-1:0]      ba_i,
   input  logic                 a10_i,
   input  logic [MASK_W-1:0]    dqm_i,
   output logic                 act_o,
   output logic                 read_o,
   output logic                 write_o,
   output logic                 pre_o,
   output logic                 refresh_o,
   output logic                 mode_o,
   output logic                 cmd_err_o,
   output logic [NUM_BANKS-1:0] bank_open_o,
   output logic [MASK_W-1:0]    rd_byte_en_o,
   output logic [MASK_W-1:0]    wr_byte_en_o
);

   logic open_ev, close_ev, close_all, access_ev, auto_close;

   sdcf_decode #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) i_decode (
      .clk_i, .rst_ni, .cke_i, .cs_ni, .ras_ni, .cas_ni, .we_ni, .ba_i, .a10_i,
      .bank_open_i  (bank_open_o),
      .open_ev_o    (open_ev),
      .close_ev_o   (close_ev),
      .close_all_o  (close_all),
      .access_ev_o  (access_ev),
      .auto_close_o (auto_close),
      .act_o, .read_o, .write_o, .pre_o, .refresh_o, .mode_o, .cmd_err_o
   );

   sdcf_bank_track #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W), .BURST_LEN(BURST_LEN)) i_banks (
      .clk_i, .rst_ni, .cke_i, .ba_i,
      .open_ev_i    (open_ev),
      .close_ev_i   (close_ev),
      .close_all_i  (close_all),
      .access_ev_i  (access_ev),
      .auto_close_i (auto_close),
      .bank_open_o
   );

   sdcf_mask_pipe #(.MASK_W(MASK_W), .RD_LAT(RD_LAT)) i_mask (
      .clk_i, .rst_ni, .cke_i, .dqm_i, .rd_byte_en_o, .wr_byte_en_o
   );

endmodule

// File: tb/test_sdram_cmd_front.sv
module test_sdram_cmd_front;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0] ba = '0;
   logic       a10 = 1'b0;
   logic [1:0] dqm = 2'b11;
   logic       act, rd, wr, pre, refr, mode, err;
   logic [3:0] banks;
   logic [1:0] rd_en, wr_en;

   always #2.5 clk = ~clk;

   sdram_cmd_front i_sdram_cmd_front (
      .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
      .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .a10_i(a10), .dqm_i(dqm),
      .act_o(act), .read_o(rd), .write_o(wr), .pre_o(pre), .refresh_o(refr),
      .mode_o(mode), .cmd_err_o(err), .bank_open_o(banks),
      .rd_byte_en_o(rd_en), .wr_byte_en_o(wr_en)
   );

   // strobe vector {act,read,write,pre,refresh,mode,err}
   localparam logic [6:0] S_NONE = 7'b0000000, S_ACT = 7'b1000000,
      S_RD = 7'b0100000, S_WR = 7'b0010000, S_PRE = 7'b0001000,
      S_REF = 7'b0000100, S_MRS = 7'b0000010, S_ERR = 7'b0000001;

   typedef struct {
      logic [6:0] strb;
      logic [3:0] banks;
      logic [1:0] rd_en;
      string      tag;
   } exp_t;

   exp_t       sb_q[$];
   int         checks = 0, fails = 0;
   logic [1:0] p1 = 2'b00, p2 = 2'b00;
   bit         done = 0;

   function automatic void check(string tag, logic [7:0] got, logic [7:0] want);
      checks++;
      if (got !== want) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b", tag, got, want);
      end
   endfunction

   // Driver: applies one command at the falling edge and queues the expected result.
   task automatic step(input logic c_ke, input logic c_s, input logic [2:0] rcw,
                       input logic [1:0] b, input logic a, input logic [1:0] m,
                       input logic [6:0] e_strb, input logic [3:0] e_banks,
                       input string tag);
      exp_t it;
      @(negedge clk);
      cke = c_ke; cs_n = c_s; {ras_n, cas_n, we_n} = rcw; ba = b; a10 = a; dqm = m;
      if (c_ke) begin p2 = p1; p1 = ~m; end
      it.strb = e_strb; it.banks = e_banks; it.rd_en = p2; it.tag = tag;
      sb_q.push_back(it);
      #0.5;
      check({tag, " R9/R3 write strobe"}, {6'b0, wr_en}, {6'b0, (c_ke ? ~m : 2'b00)});
   endtask

   // Monitor: compares just after each rising edge.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            check({it.tag, " strobes"}, {1'b0, act, rd, wr, pre, refr, mode, err}, {1'b0, it.strb});
            check({it.tag, " banks"}, {4'b0, banks}, {4'b0, it.banks});
            check({it.tag, " R8 read enable"}, {6'b0, rd_en}, {6'b0, it.rd_en});
         end
      end
   end

   initial begin
      #100000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R10 reset strobes", {1'b0, act, rd, wr, pre, refr, mode, err}, 8'h00);
      check("R10 reset banks/rd", {2'b0, banks, rd_en}, 8'h00);
      @(negedge clk); rst_n = 1'b1;
      step(1, 0, 3'b111, 0, 0, 2'b00, S_NONE, 4'b0000, "R1 nop");
      step(1, 0, 3'b101, 0, 0, 2'b01, S_ERR,  4'b0000, "R5 read closed");
      step(1, 0, 3'b011, 1, 0, 2'b10, S_ACT,  4'b0010, "R4 act b1");
      step(1, 0, 3'b011, 1, 0, 2'b00, S_ERR,  4'b0010, "R4 act open");
      step(1, 0, 3'b011, 2, 0, 2'b11, S_ACT,  4'b0110, "R4 act b2");
      step(1, 0, 3'b100, 1, 0, 2'b01, S_WR,   4'b0110, "R1 write b1");
      step(1, 0, 3'b010, 2, 0, 2'b10, S_PRE,  4'b0010, "R6 pre single");
      step(1, 0, 3'b011, 0, 0, 2'b00, S_ACT,  4'b0011, "R4 act b0");
      step(1, 0, 3'b101, 0, 1, 2'b01, S_RD,   4'b0011, "R7 read autopre");
      step(1, 1, 3'b011, 3, 0, 2'b10, S_NONE, 4'b0011, "R2 deselected");
      step(1, 0, 3'b111, 0, 0, 2'b00, S_NONE, 4'b0011, "R7 countdown");
      step(0, 0, 3'b111, 0, 0, 2'b11, S_NONE, 4'b0011, "R3 frozen countdown");
      step(1, 0, 3'b111, 0, 0, 2'b01, S_NONE, 4'b0011, "R7 countdown late");
      step(1, 0, 3'b111, 0, 0, 2'b10, S_NONE, 4'b0010, "R7 autopre close");
      step(1, 0, 3'b001, 0, 0, 2'b00, S_REF,  4'b0010, "R1 refresh");
      step(1, 0, 3'b000, 0, 0, 2'b01, S_MRS,  4'b0010, "R1 mode set");
      step(1, 0, 3'b011, 3, 0, 2'b10, S_ACT,  4'b1010, "R1 act b3");
      step(0, 0, 3'b010, 0, 1, 2'b01, S_ACT,  4'b1010, "R3 frozen precharge");
      step(1, 0, 3'b010, 0, 1, 2'b11, S_PRE,  4'b0000, "R6 pre all");
      step(1, 0, 3'b110, 0, 0, 2'b00, S_NONE, 4'b0000, "R1 burst stop");
      step(1, 0, 3'b100, 2, 0, 2'b10, S_ERR,  4'b0000, "R5 write closed");
      step(1, 0, 3'b111, 0, 0, 2'b00, S_NONE, 4'b0000, "R8 drain");
      repeat (3) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule